// File: doc/BRIEF.md
# Synchronous Burst SRAM With Stall

A cycle-accurate, synthesizable model of a synchronous SRAM that streams data with no dead cycles between reads and writes. Every control input is sampled on the rising clock edge. A cycle with the load strobe low starts a new beat sequence at the presented address, and that cycle alone decides whether the sequence reads or writes. A cycle with the load strobe high steps the sequence to the next word of its aligned four-word block, and it keeps the type chosen at the load.

Reads are flow-through. After the edge that captures a read beat, the word at that address is driven combinationally during the following cycle and the output enable is high. Writes are late by one edge. The data for a write beat is placed on the input bus in the cycle after its address cycle and is stored at the next enabled edge, under the byte-lane enables that were sampled with the address. Holding the active-low clock enable high freezes every register and leaves the outputs unchanged. The 36-bit word has four 9-bit lanes. The array depth is a parameter.

Top module: `sram_burst_ft`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge, taking priority over the clock enable) cancels the beat in flight, including a pending write, and drives `dout_oe` low. Array contents are kept.
- R2: At an enabled edge with `ld_n` low, the block captures `addr` and the cycle type (`we_n` low = write, high = read). For a read, `dout` equals the stored word at that address and `dout_oe` is 1 during the following cycle.
- R3: For a write beat captured at edge k, the word on `din` at the next enabled edge is stored at that beat's address. An idle cycle is never required.
- R4: `bw_n` is active low and is sampled in the same cycle as the beat's address. `bw_n[0]` gates bits 8:0, `bw_n[1]` gates bits 17:9, `bw_n[2]` gates bits 26:18 and `bw_n[3]` gates bits 35:27. A lane whose enable is high keeps its stored bits.
- R5: A write beat with `bw_n` = 4'b0000 replaces all 36 bits of the word.
- R6: At an enabled edge with `ld_n` high, the beat address keeps its upper bits and adds one to its two low bits modulo 4. This continues to wrap for any number of beats.
- R7: `we_n` is ignored on advance cycles. A sequence stays read or write until the next load.
- R8: While `clken_n` is high, edges have no effect. No write occurs, the beat address does not change, and `dout` and `dout_oe` hold their values.
- R9: Read and write loads may alternate on consecutive cycles, and each gives correct data.
- R10: `dout_oe` is 1 only during read beats. It is 0 during write beats and when no beat is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clken_n | input | 1 | Active-low clock enable; high stalls the block |
| ld_n | input | 1 | Low = load new address, high = advance in block |
| we_n | input | 1 | Cycle type on loads: low = write, high = read |
| addr | input | AW | Word address (AW = clog2(DEPTH)) |
| bw_n | input | 4 | Active-low byte-lane write enables |
| din | input | 36 | Write data, presented one cycle after its address |
| dout | output | 36 | Flow-through read data |
| dout_oe | output | 1 | Data output enable, high on read beats |

## Verification
A wrong beat address or a wrong counter step shows on `dout` in the cycle right after the faulty edge, because every address holds a distinct word. A beat type that is lost on an advance shows at once as a wrong `dout_oe`. A stray or missing write, or a wrong lane mask, stays hidden until that address is read again. The sweeps therefore read back every word they write, soon after writing it, and again after stalls and after a reset.

// File: rtl/sram_burst_pkg.sv
// Shared constants and types for the burst SRAM model.
// Assumes a fixed 36-bit word made of four 9-bit lanes.
package sram_burst_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic {
        BEAT_RD = 1'b0,
        BEAT_WR = 1'b1
    } beat_kind_t;
endpackage

// File: rtl/beat_tracker.sv
// Holds the beat in flight: address, read/write kind, lane mask and a valid flag.
// A load takes the new address and kind. An advance steps the low two address
// bits modulo 4 and keeps the kind. Assumes AW >= 2 and an active-low clock enable.
module beat_tracker
    import sram_burst_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clken_n,
    input  logic             ld_n,
    input  logic             we_n,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] bw_n,
    output logic [AW-1:0]    beat_addr,
    output beat_kind_t       beat_kind,
    output logic [LANES-1:0] beat_bw_n,
    output logic             beat_valid
);
    logic [1:0] next_cnt;

    // next position inside the aligned four-word block
    always_comb next_cnt = beat_addr[1:0] + 2'd1;

    // register the beat on enabled edges; reset clears only the valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_valid <= 1'b0;
        end else if (!clken_n) begin
            if (!ld_n) begin
                beat_addr  <= addr;
                beat_kind  <= we_n ? BEAT_RD : BEAT_WR;
                beat_bw_n  <= bw_n;
                beat_valid <= 1'b1;
            end else if (beat_valid) begin
                beat_addr  <= {beat_addr[AW-1:2], next_cnt};
                beat_bw_n  <= bw_n;
            end
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clken_n |=> ($stable(beat_addr) && $stable(beat_valid) && $stable(beat_kind)));

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clken_n && !ld_n) |=> (beat_valid && beat_addr == $past(addr)
                                 && (beat_kind == BEAT_WR) == !$past(we_n)));

    // R6
    wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clken_n && ld_n && beat_valid) |=>
            (beat_addr[AW-1:2] == $past(beat_addr[AW-1:2])
             && beat_addr[1:0] == 2'($past(beat_addr[1:0]) + 2'd1)));

    // R7
    kind_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clken_n && ld_n && beat_valid) |=> $stable(beat_kind));
endmodule

// File: rtl/lane_array.sv
// One 9-bit lane of the storage array. The single address is shared by the
// write and the read. The read is combinational (flow-through); the write happens
// on the clock edge when wr_en is high. Contents are never reset.
module lane_array #(
    parameter int DEPTH = 64,
    parameter int W     = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // store the lane on a granted write
    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    // flow-through read of the current beat address
    always_comb rdata = mem[addr];

    // R4
    lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/sram_burst_ft.sv
// Top of the burst SRAM model. The beat tracker holds the beat in flight, and
// four lane arrays store the word. A write beat commits din at the next enabled
// edge; a read beat drives its word combinationally with dout_oe high.
// Assumes DEPTH is a power of two and at least 4.
module sram_burst_ft
    import sram_burst_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clken_n,
    input  logic          ld_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [3:0]    bw_n,
    input  logic [35:0]   din,
    output logic [35:0]   dout,
    output logic          dout_oe
);
    logic [AW-1:0]    beat_addr;
    beat_kind_t       beat_kind;
    logic [LANES-1:0] beat_bw_n;
    logic             beat_valid;
    logic             commit;

    beat_tracker #(.AW(AW)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clken_n   (clken_n),
        .ld_n      (ld_n),
        .we_n      (we_n),
        .addr      (addr),
        .bw_n      (bw_n),
        .beat_addr (beat_addr),
        .beat_kind (beat_kind),
        .beat_bw_n (beat_bw_n),
        .beat_valid(beat_valid)
    );

    // a pending write commits at an enabled edge outside reset
    always_comb commit = rst_n && !clken_n && beat_valid && (beat_kind == BEAT_WR);

    // the output is enabled for read beats only
    always_comb dout_oe = beat_valid && (beat_kind == BEAT_RD);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_array #(.DEPTH(DEPTH), .W(LANE_W)) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_en(commit && !beat_bw_n[g]),
            .addr (beat_addr),
            .wdata(din[g*LANE_W +: LANE_W]),
            .rdata(dout[g*LANE_W +: LANE_W])
        );
    end

    // R8
    out_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clken_n |=> ($stable(dout) && $stable(dout_oe)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !dout_oe);

    // R10
    oe_load_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clken_n && !ld_n) |=> (dout_oe == $past(we_n)));
endmodule

// File: tb/sim_sram_burst_ft.sv
`timescale 1ns/1ps
module sim_sram_burst_ft;
    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clken_n = 1'b0;
    logic          ld_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [3:0]    bw_n = 4'hF;
    logic [35:0]   din = '0;
    logic [35:0]   dout;
    logic          dout_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model of the beat in flight and of the array
    logic [35:0]   ref_mem [DEPTH];
    logic [AW-1:0] m_addr = '0;
    logic          m_wr = 1'b0;
    logic [3:0]    m_bw = 4'hF;
    logic          m_valid = 1'b0;

    always #2 clk = ~clk;

    sram_burst_ft #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .clken_n(clken_n), .ld_n(ld_n), .we_n(we_n),
        .addr(addr), .bw_n(bw_n), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    function automatic logic [35:0] dfn(input int a, input int s);
        return 36'((a * 40503) + (s * 7919)) ^ 36'hA5A5A5A5A;
    endfunction

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: drive at the falling edge, update the model at the rising edge, then check
    task automatic step(input logic ld, input logic we, input int a, input logic [3:0] bw,
                        input int salt, input logic hold, input string tag);
        logic [35:0] wd;
        @(negedge clk);
        wd = dfn(int'(m_addr), salt);
        if (hold) wd = ~wd;
        clken_n = hold; ld_n = ld; we_n = we; addr = AW'(a); bw_n = bw; din = wd;
        @(posedge clk);
        if (!rst_n) begin
            m_valid = 1'b0;
        end else if (!hold) begin
            if (m_valid && m_wr)
                for (int l = 0; l < 4; l++)
                    if (!m_bw[l]) ref_mem[m_addr][l*9 +: 9] = wd[l*9 +: 9];
            if (!ld) begin
                m_addr = AW'(a); m_wr = !we; m_bw = bw; m_valid = 1'b1;
            end else if (m_valid) begin
                m_addr = {m_addr[AW-1:2], 2'(m_addr[1:0] + 2'd1)};
                m_bw = bw;
            end
        end
        #1;
        check({tag, " R10 oe"}, 36'(dout_oe), 36'(m_valid && !m_wr));
        if (m_valid && !m_wr) check({tag, " data"}, dout, ref_mem[m_addr]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ld_n = 1'b1; clken_n = 1'b0;
        @(posedge clk);
        m_valid = 1'b0;
        #1;
        check("R1 oe after reset", 36'(dout_oe), 36'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [35:0] held;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 'x;
        do_reset();
        do_reset();

        // R5 R3: fill every word through full-width write bursts, one load per block
        for (int b = 0; b < DEPTH; b += 4) begin
            step(1'b0, 1'b0, b, 4'b0000, 1, 1'b0, "R5 fill load");
            for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 0, 4'b0000, 1, 1'b0, "R3 fill adv");
        end
        // R6: read bursts from every start offset, running past four beats
        for (int s = 0; s < DEPTH; s++) begin
            step(1'b0, 1'b1, s, 4'hF, 0, 1'b0, "R2 read load");
            for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 0, 4'hF, 0, 1'b0, "R6 wrap");
        end
        // R4 R9: every lane mask, with write and read loads alternating on consecutive cycles
        for (int p = 0; p < 16; p++) begin
            step(1'b0, 1'b0, p + 16, 4'(p), 10 + p, 1'b0, "R4 partial wr");
            step(1'b0, 1'b1, p + 16, 4'hF, 0, 1'b0, "R9 rd after wr");
            step(1'b0, 1'b0, p + 32, 4'(~p), 40 + p, 1'b0, "R9 wr after rd");
            step(1'b0, 1'b1, p + 32, 4'hF, 0, 1'b0, "R4 readback");
        end
        // R4: write burst with a different mask on each advance beat
        step(1'b0, 1'b0, 5, 4'b1110, 70, 1'b0, "R4 burst mask");
        step(1'b1, 1'b1, 0, 4'b1101, 70, 1'b0, "R4 burst mask");
        step(1'b1, 1'b1, 0, 4'b1011, 70, 1'b0, "R4 burst mask");
        step(1'b1, 1'b1, 0, 4'b0111, 70, 1'b0, "R4 burst mask");
        step(1'b0, 1'b1, 4, 4'hF, 0, 1'b0, "R4 mask read");
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 0, 4'hF, 0, 1'b0, "R4 mask read");

        // R8: read burst stalled mid-way for several cycles
        step(1'b0, 1'b1, 9, 4'hF, 0, 1'b0, "R8 read");
        step(1'b1, 1'b1, 0, 4'hF, 0, 1'b0, "R8 read");
        held = dout;
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b0, 50, 4'h0, 0, 1'b1, "R8 stall");
            check("R8 dout held", dout, held);
        end
        step(1'b1, 1'b1, 0, 4'hF, 0, 1'b0, "R8 resume");
        step(1'b1, 1'b1, 0, 4'hF, 0, 1'b0, "R8 resume");
        // R8: write burst stalled mid-way; din differs during the stall and must not be stored
        step(1'b0, 1'b0, 12, 4'h0, 80, 1'b0, "R8 wr");
        for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 0, 4'h0, 80, 1'b1, "R8 wr stall");
        step(1'b1, 1'b1, 0, 4'h0, 81, 1'b0, "R8 wr");
        step(1'b1, 1'b1, 0, 4'h0, 82, 1'b0, "R8 wr");
        step(1'b0, 1'b1, 12, 4'hF, 0, 1'b0, "R8 readback");
        for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 0, 4'hF, 0, 1'b0, "R8 readback");

        // R7: we_n low on advances of a read burst must not write
        step(1'b0, 1'b1, 20, 4'hF, 0, 1'b0, "R7 rd");
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 0, 4'h0, 90, 1'b0, "R7 rd keeps");
        // R7: we_n high on advances of a write burst keeps writing
        step(1'b0, 1'b0, 24, 4'h0, 91, 1'b0, "R7 wr");
        for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 0, 4'h0, 92, 1'b0, "R7 wr keeps");
        step(1'b0, 1'b1, 20, 4'hF, 0, 1'b0, "R7 readback");
        for (int k = 0; k < 7; k++) step(1'b1, 1'b1, 0, 4'hF, 0, 1'b0, "R7 readback");

        // R1: reset while a write is pending cancels it and keeps the array
        step(1'b0, 1'b0, 40, 4'h0, 99, 1'b0, "R1 wr pending");
        do_reset();
        step(1'b1, 1'b1, 0, 4'hF, 0, 1'b0, "R1 idle adv");
        for (int a = 0; a < DEPTH; a++) step(1'b0, 1'b1, a, 4'hF, 0, 1'b0, "R1 retained");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule